// File: doc/BRIEF.md
# Oversampling Serial Receiver with Sleep and Wakeup

This block receives asynchronous serial frames. Each frame has one low start bit, eight data bits sent least significant bit first, and one high stop bit. A sample-rate tick clocks the receiver at sixteen samples per bit. A falling edge on the idle line sets the phase of the sample counter. Each bit is then decided by a majority of three samples taken in the middle of the bit. When enabled, later edges on the data bits nudge the counter back into phase, so the receiver tolerates a slower or faster sender. Each finished payload goes into one holding register. That register has a full flag, an overrun flag, a noise flag and a framing flag, and a read strobe clears all four.

Software can put the receiver to sleep with a one-cycle request. While asleep, the receiver still decodes frames but does not store them, and it waits for one of two wakeup events:
- **Address-mark method:** a frame whose most significant data bit is set is stored and wakes the receiver straight into normal reception.
- **Idle-line method:** a full frame time of quiet line wakes the receiver into a ready state. The next frame is then stored normally.

The block is meant to sit behind a register interface. The interface reads the data port and pulses the read strobe. It uses the interrupt output as the data-available request.

Top module: `rxw_uart_rx`

## Requirements
- R1: With 16 ticks per bit, a clean frame delivers its eight data bits, first bit into `rx_data[0]`. Each bit is the majority of the samples at tick positions 7, 8 and 9 of the bit, counted from 0 at the bit's first tick.
- R2: `rx_noise` is set when the three voting samples of any data bit or of the stop bit disagree. The majority value is still used.
- R3: `rx_frame_err` is set when the stop bit votes low.
- R4: A stored frame sets `rx_full`. `rx_irq` is high exactly when `rx_full` and `cfg_rie` are both high.
- R5: When a frame would be stored while `rx_full` is set and no read is in that cycle:
  - `rx_overrun` is set;
  - `rx_data` and `rx_full` stay unchanged;
  - the new payload is dropped.
- R6: A pulse on `rd_strobe` clears `rx_full`, `rx_overrun`, `rx_noise` and `rx_frame_err`. A flag set by a frame that finishes in the same cycle wins.
- R7: A low pulse whose middle-of-bit vote is high is treated as a false start bit. It is ignored, and no frame or flag results.
- R8: With `cfg_resync` high, an edge seen within 3 ticks of the expected bit boundary re-phases the counter during data bits. Example: a sender at 17 ticks per bit sending 0x55 is received cleanly. With `cfg_resync` low, the same stream shows a framing error.
- R9: `rx_mode` encodes 0 = Ready, 1 = Run, 2 = Wakeup:
  - reset gives Ready;
  - a one-cycle `sleep_req` enters Wakeup;
  - the first completed frame moves Ready to Run.
- R10: Address-mark wakeup (`cfg_addr_wake` = 1), while in Wakeup:
  - a frame with bit 7 clear is dropped;
  - a frame with bit 7 set moves to Run and is stored if `rx_full` is 0;
  - otherwise that frame sets `rx_overrun`.
- R11: Idle-line wakeup (`cfg_addr_wake` = 0), while in Wakeup:
  - every frame is dropped, whatever bit 7 holds;
  - 160 consecutive high samples with the receiver between frames, counted from the sleep request or the last low sample, move to Ready.
- R12: Noise and framing flags are still set by frames that are dropped in the Wakeup state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_line | input | 1 | Serial input, idle high, asynchronous to clk |
| smp_tick | input | 1 | One-cycle sample enable, 16 per bit time |
| rd_strobe | input | 1 | Read pulse, clears full and status flags |
| sleep_req | input | 1 | One-cycle pulse that enters the Wakeup state |
| cfg_addr_wake | input | 1 | Wakeup method: 1 address-mark, 0 idle-line |
| cfg_rie | input | 1 | Receive interrupt enable |
| cfg_resync | input | 1 | Enable counter re-phasing on data-bit edges |
| rx_data | output | 8 | Holding register contents |
| rx_full | output | 1 | Holding register holds unread data |
| rx_overrun | output | 1 | A payload was dropped because the register was full |
| rx_noise | output | 1 | Voting samples disagreed in a frame |
| rx_frame_err | output | 1 | Stop bit voted low |
| rx_irq | output | 1 | Receive interrupt request |
| rx_mode | output | 2 | 0 Ready, 1 Run, 2 Wakeup |

## Verification
The assertions assume the configuration inputs stay steady while a frame is in flight. They also assume `sleep_req` is not pulsed in the same cycle as a frame completion or an idle detection; the wake-transition checks exclude that cycle. The stimulus meets these assumptions:
- configuration is changed only between frames, with the line idle;
- sleep requests and read strobes are issued only while the line rests high between frames;
- the line changes only between sample ticks, so every sample the receiver takes is a value the bench intended.

// File: rtl/rxw_pkg.sv
// Shared types for the oversampling serial receiver.
// Assumes: nothing beyond IEEE 1800-2017 enum support.
package rxw_pkg;
    typedef enum logic [1:0] {
        MODE_READY = 2'd0,
        MODE_RUN   = 2'd1,
        MODE_WAKE  = 2'd2
    } rx_mode_e;

    typedef enum logic [1:0] {
        BS_IDLE  = 2'd0,
        BS_START = 2'd1,
        BS_DATA  = 2'd2,
        BS_STOP  = 2'd3
    } bit_st_e;
endpackage

// File: rtl/rxw_sync.sv
// Multi-flop synchroniser for the asynchronous serial line.
// Assumes: STAGES >= 2; resets to the idle (high) line level.
module rxw_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh;

    // shift the line through the synchroniser chain
    always_ff @(posedge clk) begin
        if (!rst_n) sh <= '1;
        else        sh <= {sh[STAGES-2:0], d};
    end

    assign q = sh[STAGES-1];
endmodule

// File: rtl/rxw_bit_engine.sv
// Frame assembler: start detection, cyclic sample counter, 3-sample
// majority vote, optional re-phasing on data-bit edges.
// Assumes: line is already synchronised; tick is a one-cycle enable.
// The detecting tick of a start edge is sample 0 of the start bit.
module rxw_bit_engine
    import rxw_pkg::*;
#(
    parameter int SAMPLES   = 16,
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 line,
    input  logic                 resync_en,
    output logic                 frm_done,
    output logic [DATA_BITS-1:0] frm_data,
    output logic                 frm_noise,
    output logic                 frm_ferr,
    output logic                 busy
);
    localparam int CW  = $clog2(SAMPLES);
    localparam int BW  = $clog2(DATA_BITS + 1);
    localparam int WIN = SAMPLES / 4 - 1;
    localparam logic [CW-1:0] V0   = CW'(SAMPLES / 2 - 1);
    localparam logic [CW-1:0] V1   = CW'(SAMPLES / 2);
    localparam logic [CW-1:0] V2   = CW'(SAMPLES / 2 + 1);
    localparam logic [CW-1:0] LAST = CW'(SAMPLES - 1);
    localparam logic [CW-1:0] ONE  = CW'(1);

    bit_st_e              st;
    logic [CW-1:0]        cnt;
    logic [BW-1:0]        bidx;
    logic [DATA_BITS-1:0] shreg;
    logic                 s0, s1, last_s, noise_acc;
    logic                 edge_seen, early, late, vote, disagree;

    // edge, re-phase window and vote decode for the current tick
    always_comb begin
        edge_seen = (line != last_s);
        early     = resync_en && (st == BS_DATA) && edge_seen && (cnt >= CW'(SAMPLES - WIN));
        late      = resync_en && (st == BS_DATA) && edge_seen && (cnt != '0) && (cnt <= CW'(WIN));
        vote      = (s0 & s1) | (s0 & line) | (s1 & line);
        disagree  = !((s0 == s1) && (s1 == line));
    end

    assign busy = (st != BS_IDLE);

    // per-tick sampling, bit advance and frame completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= BS_IDLE; cnt <= '0; bidx <= '0; shreg <= '0;
            s0 <= 1'b1; s1 <= 1'b1; last_s <= 1'b1; noise_acc <= 1'b0;
            frm_done <= 1'b0; frm_data <= '0; frm_noise <= 1'b0; frm_ferr <= 1'b0;
        end else begin
            frm_done <= 1'b0;
            if (tick) begin
                last_s <= line;
                if (st == BS_IDLE) begin
                    if (!line) begin
                        st <= BS_START; cnt <= ONE; noise_acc <= 1'b0;
                    end
                end else begin
                    if (early || late)    cnt <= ONE;
                    else if (cnt == LAST) cnt <= '0;
                    else                  cnt <= cnt + ONE;
                    if (cnt == V0) s0 <= line;
                    if (cnt == V1) s1 <= line;
                    if (cnt == V2) begin
                        case (st)
                            BS_START: if (vote) st <= BS_IDLE;
                            BS_DATA: begin
                                shreg <= {vote, shreg[DATA_BITS-1:1]};
                                if (disagree) noise_acc <= 1'b1;
                            end
                            BS_STOP: begin
                                frm_done  <= 1'b1;
                                frm_data  <= shreg;
                                frm_ferr  <= !vote;
                                frm_noise <= noise_acc | disagree;
                                st        <= BS_IDLE;
                            end
                            default: ;
                        endcase
                    end
                    if ((cnt == LAST) || early) begin
                        case (st)
                            BS_START: begin st <= BS_DATA; bidx <= '0; end
                            BS_DATA: begin
                                if (bidx == BW'(DATA_BITS - 1)) st <= BS_STOP;
                                else bidx <= bidx + 1'b1;
                            end
                            default: ;
                        endcase
                    end
                end
            end
        end
    end
endmodule

// File: rtl/rxw_idle_det.sv
// Idle-line detector: pulses once after FRAME_TICKS consecutive high
// samples while no frame is in progress.
// Assumes: clr restarts the count (used on a sleep request).
module rxw_idle_det #(
    parameter int FRAME_TICKS = 160
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic line,
    input  logic busy,
    input  logic clr,
    output logic idle_pulse
);
    localparam int IW = $clog2(FRAME_TICKS + 1);
    localparam logic [IW-1:0] FULL = IW'(FRAME_TICKS);

    logic [IW-1:0] run;

    // count quiet samples and saturate after one pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= '0; idle_pulse <= 1'b0;
        end else begin
            idle_pulse <= 1'b0;
            if (clr || busy) run <= '0;
            else if (tick) begin
                if (!line) run <= '0;
                else if (run != FULL) begin
                    run <= run + 1'b1;
                    if (run == FULL - 1'b1) idle_pulse <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/rxw_mode_ctl.sv
// Ready / Run / Wakeup state machine and store-acceptance decode.
// Assumes: frm_done and idle_pulse are single-cycle pulses.
module rxw_mode_ctl
    import rxw_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     sleep_req,
    input  logic     addr_mode,
    input  logic     frm_done,
    input  logic     addr_bit,
    input  logic     idle_pulse,
    output rx_mode_e mode,
    output logic     accept
);
    // a frame is stored unless asleep, except an address frame in address-mark mode
    always_comb accept = frm_done && ((mode != MODE_WAKE) || (addr_mode && addr_bit));

    // mode transitions
    always_ff @(posedge clk) begin
        if (!rst_n)         mode <= MODE_READY;
        else if (sleep_req) mode <= MODE_WAKE;
        else begin
            case (mode)
                MODE_WAKE: begin
                    if (addr_mode && frm_done && addr_bit)   mode <= MODE_RUN;
                    else if (!addr_mode && idle_pulse)       mode <= MODE_READY;
                end
                MODE_READY: if (frm_done) mode <= MODE_RUN;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/rxw_uart_rx.sv
// Top: serial receiver with holding register, status flags and wakeup.
// Assumes: smp_tick runs at SAMPLES per bit; rd_strobe is one cycle wide.
module rxw_uart_rx
    import rxw_pkg::*;
#(
    parameter int SAMPLES     = 16,
    parameter int DATA_BITS   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_line,
    input  logic                 smp_tick,
    input  logic                 rd_strobe,
    input  logic                 sleep_req,
    input  logic                 cfg_addr_wake,
    input  logic                 cfg_rie,
    input  logic                 cfg_resync,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 rx_full,
    output logic                 rx_overrun,
    output logic                 rx_noise,
    output logic                 rx_frame_err,
    output logic                 rx_irq,
    output logic [1:0]           rx_mode
);
    localparam int FRAME_TICKS = SAMPLES * (DATA_BITS + 2);

    logic                 line_s, frm_done, frm_noise, frm_ferr, busy;
    logic                 idle_pulse, accept, addr_bit, full_eff;
    logic [DATA_BITS-1:0] frm_data;
    rx_mode_e             mode;

    rxw_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(rx_line), .q(line_s)
    );

    rxw_bit_engine #(.SAMPLES(SAMPLES), .DATA_BITS(DATA_BITS)) u_eng (
        .clk(clk), .rst_n(rst_n), .tick(smp_tick), .line(line_s),
        .resync_en(cfg_resync), .frm_done(frm_done), .frm_data(frm_data),
        .frm_noise(frm_noise), .frm_ferr(frm_ferr), .busy(busy)
    );

    rxw_idle_det #(.FRAME_TICKS(FRAME_TICKS)) u_idle (
        .clk(clk), .rst_n(rst_n), .tick(smp_tick), .line(line_s),
        .busy(busy), .clr(sleep_req), .idle_pulse(idle_pulse)
    );

    assign addr_bit = frm_data[DATA_BITS-1];

    rxw_mode_ctl u_mode (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .addr_mode(cfg_addr_wake),
        .frm_done(frm_done), .addr_bit(addr_bit), .idle_pulse(idle_pulse),
        .mode(mode), .accept(accept)
    );

    // a read in the same cycle frees the register before a new store
    assign full_eff = rx_full && !rd_strobe;

    // holding register and sticky status flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data <= '0; rx_full <= 1'b0; rx_overrun <= 1'b0;
            rx_noise <= 1'b0; rx_frame_err <= 1'b0;
        end else begin
            if (rd_strobe) begin
                rx_full <= 1'b0; rx_overrun <= 1'b0;
                rx_noise <= 1'b0; rx_frame_err <= 1'b0;
            end
            if (frm_done) begin
                if (frm_noise) rx_noise     <= 1'b1;
                if (frm_ferr)  rx_frame_err <= 1'b1;
            end
            if (accept) begin
                if (full_eff) rx_overrun <= 1'b1;
                else begin
                    rx_data <= frm_data;
                    rx_full <= 1'b1;
                end
            end
        end
    end

    assign rx_irq  = rx_full && cfg_rie;
    assign rx_mode = mode;
endmodule

// File: rtl/rxw_uart_rx_chk.sv
// Property checker for rxw_uart_rx, attached with bind.
// Assumes: configuration is steady while frames are in flight.
module rxw_uart_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_strobe,
    input logic       sleep_req,
    input logic       cfg_addr_wake,
    input logic [7:0] rx_data,
    input logic       rx_full,
    input logic       rx_overrun,
    input logic [1:0] rx_mode,
    input logic       frm_done,
    input logic       idle_pulse,
    input logic       addr_bit
);
    // R5
    ovr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_done && rx_full && !rd_strobe && rx_mode != 2'd2)
        |=> (rx_overrun && rx_full && $stable(rx_data)));

    // R4
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && !rd_strobe) |=> rx_full);

    // R6
    read_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !frm_done) |=> (!rx_full && !rx_overrun));

    // R11
    idle_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_mode == 2'd2 && !cfg_addr_wake) |=> ($stable(rx_data) && !$rose(rx_full)));

    // R11
    idle_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_mode == 2'd2 && !cfg_addr_wake && idle_pulse && !sleep_req) |=> (rx_mode == 2'd0));

    // R10
    addr_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_mode == 2'd2 && cfg_addr_wake && frm_done && addr_bit && !sleep_req)
        |=> (rx_mode == 2'd1 && rx_full));
endmodule

bind rxw_uart_rx rxw_uart_rx_chk u_chk (
    .clk(clk), .rst_n(rst_n), .rd_strobe(rd_strobe), .sleep_req(sleep_req),
    .cfg_addr_wake(cfg_addr_wake), .rx_data(rx_data), .rx_full(rx_full),
    .rx_overrun(rx_overrun), .rx_mode(rx_mode), .frm_done(frm_done),
    .idle_pulse(idle_pulse), .addr_bit(addr_bit)
);

// File: tb/sim_rxw_uart_rx.sv
// Bench for rxw_uart_rx: table-driven frames, then directed corner cases.
module sim_rxw_uart_rx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_line = 1'b1, smp_tick = 1'b0, rd_strobe = 1'b0, sleep_req = 1'b0;
    logic       cfg_addr_wake = 1'b0, cfg_rie = 1'b1, cfg_resync = 1'b0;
    logic [7:0] rx_data;
    logic       rx_full, rx_overrun, rx_noise, rx_frame_err, rx_irq;
    logic [1:0] rx_mode;
    int n_chk = 0;
    int n_bad = 0;

    // {stop bit level, data byte}
    localparam logic [8:0] VEC [7] = '{9'h100, 9'h1FF, 9'h1A5, 9'h13C, 9'h181, 9'h05A, 9'h17E};

    always #4 clk = ~clk;

    rxw_uart_rx u0 (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .smp_tick(smp_tick),
        .rd_strobe(rd_strobe), .sleep_req(sleep_req), .cfg_addr_wake(cfg_addr_wake),
        .cfg_rie(cfg_rie), .cfg_resync(cfg_resync), .rx_data(rx_data),
        .rx_full(rx_full), .rx_overrun(rx_overrun), .rx_noise(rx_noise),
        .rx_frame_err(rx_frame_err), .rx_irq(rx_irq), .rx_mode(rx_mode)
    );

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
        end
    endtask

    // one sample slot: line value held across one tick
    task automatic slot(input logic v);
        rx_line = v;
        repeat (3) @(posedge clk);
        #1 smp_tick = 1'b1;
        @(posedge clk);
        #1 smp_tick = 1'b0;
    endtask

    // gbit: 0 start, 1..8 data, 9 stop; gslot inverted inside that bit
    task automatic send_frame(input logic [7:0] b, input logic stop_v, input int spb,
                              input int gbit, input int gslot);
        for (int k = 0; k < 10; k++) begin
            logic v;
            v = (k == 0) ? 1'b0 : (k == 9) ? stop_v : b[k-1];
            for (int s = 0; s < spb; s++) slot((k == gbit && s == gslot) ? ~v : v);
        end
        repeat (4) slot(1'b1);
        @(negedge clk);
    endtask

    task automatic do_read();
        @(posedge clk); #1 rd_strobe = 1'b1;
        @(posedge clk); #1 rd_strobe = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_sleep();
        @(posedge clk); #1 sleep_req = 1'b1;
        @(posedge clk); #1 sleep_req = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(8 * 190000);
        n_bad++;
        $display("FAIL watchdog act=hung exp=finished");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R9 reset mode", 32'(rx_mode), 32'd0);
        chk("R4 reset full", 32'(rx_full), 32'd0);
        chk("R4 reset irq", 32'(rx_irq), 32'd0);
        chk("R5 reset overrun", 32'(rx_overrun), 32'd0);
        chk("R1 reset data", 32'(rx_data), 32'd0);
        repeat (20) slot(1'b1);

        // table of clean and bad-stop frames
        for (int i = 0; i < 7; i++) begin
            send_frame(VEC[i][7:0], VEC[i][8], 16, -1, 0);
            chk("R1 data", 32'(rx_data), 32'(VEC[i][7:0]));
            chk("R4 full", 32'(rx_full), 32'd1);
            chk("R4 irq", 32'(rx_irq), 32'd1);
            chk("R3 frame err", 32'(rx_frame_err), 32'(!VEC[i][8]));
            chk("R2 no noise", 32'(rx_noise), 32'd0);
            chk("R9 run after frame", 32'(rx_mode), 32'd1);
            do_read();
            chk("R6 read clears full", 32'(rx_full), 32'd0);
            chk("R6 read clears ferr", 32'(rx_frame_err), 32'd0);
        end

        // R2 glitch on middle vote of data bit 3
        send_frame(8'hC3, 1'b1, 16, 3, 8);
        chk("R2 noise set", 32'(rx_noise), 32'd1);
        chk("R2 majority data", 32'(rx_data), 32'hC3);
        do_read();
        chk("R6 read clears noise", 32'(rx_noise), 32'd0);

        // R7 short low pulse is a false start
        for (int s = 0; s < 5; s++) slot(1'b0);
        repeat (30) slot(1'b1);
        @(negedge clk);
        chk("R7 false start no frame", 32'(rx_full), 32'd0);
        chk("R7 false start no ferr", 32'(rx_frame_err), 32'd0);

        // R5 overrun keeps first payload
        send_frame(8'h11, 1'b1, 16, -1, 0);
        send_frame(8'h22, 1'b1, 16, -1, 0);
        chk("R5 overrun set", 32'(rx_overrun), 32'd1);
        chk("R5 data kept", 32'(rx_data), 32'h11);
        chk("R5 full kept", 32'(rx_full), 32'd1);
        do_read();
        chk("R6 read clears overrun", 32'(rx_overrun), 32'd0);

        // R8 slow sender with and without re-phasing
        cfg_resync = 1'b1;
        send_frame(8'h55, 1'b1, 17, -1, 0);
        chk("R8 resync data", 32'(rx_data), 32'h55);
        chk("R8 resync no ferr", 32'(rx_frame_err), 32'd0);
        chk("R8 resync no noise", 32'(rx_noise), 32'd0);
        do_read();
        cfg_resync = 1'b0;
        send_frame(8'h55, 1'b1, 17, -1, 0);
        chk("R8 no resync ferr", 32'(rx_frame_err), 32'd1);
        do_read();

        // R4 interrupt masked
        cfg_rie = 1'b0;
        send_frame(8'h66, 1'b1, 16, -1, 0);
        chk("R4 irq masked", 32'(rx_irq), 32'd0);
        chk("R4 full unmasked", 32'(rx_full), 32'd1);
        do_read();
        cfg_rie = 1'b1;

        // R10 address-mark wakeup
        cfg_addr_wake = 1'b1;
        do_sleep();
        chk("R9 sleep enters wakeup", 32'(rx_mode), 32'd2);
        send_frame(8'h12, 1'b1, 16, -1, 0);
        chk("R10 non-address dropped", 32'(rx_full), 32'd0);
        chk("R10 still asleep", 32'(rx_mode), 32'd2);
        chk("R10 data unchanged", 32'(rx_data), 32'h66);
        send_frame(8'h12, 1'b0, 16, -1, 0);
        chk("R12 ferr while asleep", 32'(rx_frame_err), 32'd1);
        chk("R12 dropped frame not stored", 32'(rx_full), 32'd0);
        do_read();
        send_frame(8'h85, 1'b1, 16, -1, 0);
        chk("R10 address stored", 32'(rx_data), 32'h85);
        chk("R10 to run", 32'(rx_mode), 32'd1);
        chk("R10 irq", 32'(rx_irq), 32'd1);
        do_read();
        send_frame(8'h44, 1'b1, 16, -1, 0);
        do_sleep();
        send_frame(8'h90, 1'b1, 16, -1, 0);
        chk("R10 overrun when full", 32'(rx_overrun), 32'd1);
        chk("R10 data kept", 32'(rx_data), 32'h44);
        chk("R10 run after overrun", 32'(rx_mode), 32'd1);
        do_read();

        // R11 idle-line wakeup
        cfg_addr_wake = 1'b0;
        do_sleep();
        send_frame(8'hF0, 1'b1, 16, -1, 0);
        chk("R11 frame dropped", 32'(rx_full), 32'd0);
        chk("R11 still asleep", 32'(rx_mode), 32'd2);
        repeat (160) slot(1'b1);
        @(negedge clk);
        chk("R11 idle to ready", 32'(rx_mode), 32'd0);
        send_frame(8'h3A, 1'b1, 16, -1, 0);
        chk("R11 next frame stored", 32'(rx_data), 32'h3A);
        chk("R9 ready to run", 32'(rx_mode), 32'd1);
        do_read();

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule